// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit with HI/LO Result Registers

This unit performs integer multiplication and division for a 32-bit load-store processor core. A one-cycle start pulse, together with two operands and a 2-bit operation select, launches a radix-2 iterative operation. The operation can be a signed or unsigned multiply, or a signed or unsigned divide. The unit raises `busy` for the whole run. It then pulses `done` for one cycle, on the same cycle that the results land in the two dedicated result registers.

The two result registers serve every operation. After a multiply, they hold the upper and lower halves of the 64-bit product. After a divide, they hold the remainder and the quotient. The core reaches them only through the two read ports `hi_q` and `lo_q`, which feed the move-from-high and move-from-low instructions. A run takes one setup cycle plus one cycle per operand bit. Signed operations run on operand magnitudes, and the signs are fixed up at the end.

Top module: `muldiv_hilo`

## Requirements
- R1: While `rst_n` is low, and after it is released, `hi_q`, `lo_q`, `busy` and `done` are all zero until an operation completes.
- R2: A `start` sampled high while `busy` is low is accepted. `busy` is high for the next 33 cycles (one setup cycle plus 32 iterations). On the following cycle `busy` is low and `done` is high for exactly one cycle.
- R3: `op` = 2'b00 is a signed multiply. Both operands are two's complement, and the 64-bit product is split with bits 63..32 in HI and bits 31..0 in LO.
- R4: `op` = 2'b01 is an unsigned multiply. Both operands are natural numbers, and the 64-bit product is placed in HI (upper half) and LO (lower half).
- R5: `op` = 2'b10 is a signed divide. LO receives the quotient truncated toward zero and HI the remainder, which carries the dividend's sign. The case 0x80000000 / 0xFFFFFFFF gives LO = 0x80000000 and HI = 0.
- R6: `op` = 2'b11 is an unsigned divide. LO receives the unsigned quotient and HI the unsigned remainder.
- R7: A divide with a zero divisor, signed or unsigned, raises no error. It yields LO = 0xFFFFFFFF and HI equal to the dividend.
- R8: A `start` sampled while `busy` is high is ignored. The running operation's result is the one that lands, and HI/LO keep their previous values until it does.
- R9: `hi_q` and `lo_q` change only on the cycle `done` is high, and `busy` and `done` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation when the unit is idle |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| src_a | input | 32 | Multiplicand or dividend |
| src_b | input | 32 | Multiplier or divisor |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle pulse when results are written |
| hi_q | output | 32 | HI register: product upper half or remainder |
| lo_q | output | 32 | LO register: product lower half or quotient |

## Verification
The hardest situations to reach are the ones that depend on timing relative to a running operation. One is a second `start` arriving mid-run. Another is a `start` arriving in the very cycle `done` pulses, which must be accepted because `busy` has already dropped. The stimulus produces both by timing pulses in cycles counted from the launch. It also holds `start` high across the whole run so that back-to-back launches occur. The sign corner cases are forced explicitly rather than left to chance: a negative dividend over a zero divisor, the most negative value over minus one, and the most negative value squared. A batch of random operands follows.

// File: rtl/muldiv_hilo.sv
module muldiv_hilo #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi_q,
  output logic [W-1:0] lo_q
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          setup, is_div, neg_prod, neg_quo, neg_rem;
  logic [CW-1:0] cnt;
  logic [W-1:0]  mag_a, mag_b, acc_hi, acc_lo;

  wire          sgn   = ~op[0];
  wire          a_neg = sgn & src_a[W-1];
  wire          b_neg = sgn & src_b[W-1];
  wire [W-1:0]  a_abs = a_neg ? -src_a : src_a;
  wire [W-1:0]  b_abs = b_neg ? -src_b : src_b;

  wire [W:0]    mul_sum  = {1'b0, acc_hi} + (acc_lo[0] ? {1'b0, mag_a} : '0);
  wire [W:0]    div_sh   = {acc_hi, acc_lo[W-1]};
  wire [W+1:0]  div_diff = {1'b0, div_sh} - {2'b00, mag_b};
  wire          div_ok   = ~div_diff[W+1];

  wire [W-1:0]  nxt_hi = is_div ? (div_ok ? div_diff[W-1:0] : div_sh[W-1:0])
                                : mul_sum[W:1];
  wire [W-1:0]  nxt_lo = is_div ? {acc_lo[W-2:0], div_ok}
                                : {mul_sum[0], acc_lo[W-1:1]};

  wire [2*W-1:0] prod     = {nxt_hi, nxt_lo};
  wire [2*W-1:0] prod_fix = neg_prod ? -prod : prod;
  wire [W-1:0]   fin_hi   = is_div ? (neg_rem ? -nxt_hi : nxt_hi) : prod_fix[2*W-1:W];
  wire [W-1:0]   fin_lo   = is_div ? (neg_quo ? -nxt_lo : nxt_lo) : prod_fix[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      setup    <= 1'b0;
      is_div   <= 1'b0;
      neg_prod <= 1'b0;
      neg_quo  <= 1'b0;
      neg_rem  <= 1'b0;
      cnt      <= '0;
      mag_a    <= '0;
      mag_b    <= '0;
      acc_hi   <= '0;
      acc_lo   <= '0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          setup    <= 1'b1;
          is_div   <= op[1];
          mag_a    <= a_abs;
          mag_b    <= b_abs;
          neg_prod <= a_neg ^ b_neg;
          neg_quo  <= (a_neg ^ b_neg) & (src_b != '0);
          neg_rem  <= a_neg;
        end
      end else if (setup) begin
        setup  <= 1'b0;
        cnt    <= '0;
        acc_hi <= '0;
        acc_lo <= is_div ? mag_a : mag_b;
      end else begin
        acc_hi <= nxt_hi;
        acc_lo <= nxt_lo;
        cnt    <= cnt + 1'b1;
        if (cnt == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          hi_q <= fin_hi;
          lo_q <= fin_lo;
        end
      end
    end
  end
endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] hi_q,
  input logic [W-1:0] lo_q
);
  int busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_len <= 0;
    else if (busy) busy_len <= busy_len + 1;
    else busy_len <= 0;
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_done_follows_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));

  assert_run_length_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_len == W + 1));

  assert_hold_results_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(hi_q) && $stable(lo_q)));

  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
  .done(done), .hi_q(hi_q), .lo_q(lo_q)
);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 33;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] src_a = '0, src_b = '0;
  logic        busy, done;
  logic [31:0] hi_q, lo_q;

  int checks = 0, errors = 0, cycles = 0;
  string req = "R1";

  logic        e_busy = 0, e_done = 0;
  logic [31:0] e_hi = 0, e_lo = 0, p_hi = 0, p_lo = 0;
  int          left = 0;

  muldiv_hilo uut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .src_a(src_a),
    .src_b(src_b), .busy(busy), .done(done), .hi_q(hi_q), .lo_q(lo_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic model_result(input logic [1:0] o, input logic [31:0] a,
                              input logic [31:0] b,
                              output logic [31:0] rh, output logic [31:0] rl);
    longint sp, sa, sb, q, r;
    longint unsigned up;
    case (o)
      2'b00: begin sp = longint'($signed(a)) * longint'($signed(b));
                   rh = sp[63:32]; rl = sp[31:0]; end
      2'b01: begin up = {32'd0, a} * {32'd0, b};
                   rh = up[63:32]; rl = up[31:0]; end
      default: begin
        if (b == 0) begin rh = a; rl = 32'hFFFF_FFFF; end
        else if (o == 2'b10) begin
          sa = longint'($signed(a)); sb = longint'($signed(b));
          q = sa / sb; r = sa % sb;
          rh = r[31:0]; rl = q[31:0];
        end else begin rh = a % b; rl = a / b; end
      end
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      e_busy = 0; e_done = 0; e_hi = 0; e_lo = 0; left = 0;
    end else begin
      e_done = 0;
      if (e_busy) begin
        left = left - 1;
        if (left == 0) begin e_busy = 0; e_done = 1; e_hi = p_hi; e_lo = p_lo; end
      end else if (start) begin
        e_busy = 1; left = RUN;
        model_result(op, src_a, src_b, p_hi, p_lo);
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (busy !== e_busy || done !== e_done || hi_q !== e_hi || lo_q !== e_lo) begin
      errors++;
      $display("FAIL %s: busy=%b done=%b hi=%h lo=%h expected busy=%b done=%b hi=%h lo=%h",
               req, busy, done, hi_q, lo_q, e_busy, e_done, e_hi, e_lo);
    end
  end

  task automatic launch(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    start = 1'b1; op = o; src_a = a; src_b = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] o, input logic [31:0] a, input logic [31:0] b);
    launch(o, a, b);
    repeat (RUN + 1) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    req = "R1";
    checks++;
    if (hi_q !== 0 || lo_q !== 0 || busy !== 0 || done !== 0) begin
      errors++;
      $display("FAIL R1: reset state hi=%h lo=%h busy=%b done=%b expected all zero",
               hi_q, lo_q, busy, done);
    end
    rst_n = 1'b1;
    @(negedge clk);

    req = "R3"; run_op(2'b00, 32'd7, 32'hFFFF_FFFD);
    run_op(2'b00, 32'h8000_0000, 32'h8000_0000);
    run_op(2'b00, 32'h1234_5678, 32'h0ABC_DEF0);
    req = "R4"; run_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_op(2'b01, 32'h8000_0001, 32'd3);
    req = "R5"; run_op(2'b10, 32'hFFFF_FFF9, 32'd2);
    run_op(2'b10, 32'd7, 32'hFFFF_FFFE);
    run_op(2'b10, 32'h8000_0000, 32'hFFFF_FFFF);
    req = "R6"; run_op(2'b11, 32'hFFFF_FFF9, 32'd2);
    run_op(2'b11, 32'd5, 32'd9);
    req = "R7"; run_op(2'b11, 32'h0000_1234, 32'd0);
    run_op(2'b10, 32'hFFFF_FF00, 32'd0);

    req = "R8";
    launch(2'b01, 32'd1000, 32'd1000);
    repeat (5) @(negedge clk);
    start = 1'b1; op = 2'b11; src_a = 32'd99; src_b = 32'd4;
    @(negedge clk); start = 1'b0;
    repeat (RUN - 6) @(negedge clk);
    start = 1'b1; op = 2'b10; src_a = 32'hFFFF_FF9C; src_b = 32'd7;
    @(negedge clk);
    start = 1'b0;
    repeat (RUN + 2) @(negedge clk);

    req = "R9";
    @(negedge clk);
    start = 1'b1; op = 2'b00; src_a = 32'hFFFF_FFFF; src_b = 32'd5;
    repeat (3 * RUN) @(negedge clk);
    start = 1'b0;
    repeat (RUN + 2) @(negedge clk);

    req = "R2";
    for (int i = 0; i < 40; i++)
      run_op(2'($urandom_range(0, 3)), $urandom, (i % 4 == 0) ? 32'($urandom_range(0, 9)) : $urandom);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    $display("FAIL %s: watchdog expired at cycle %0d expected completion", req, cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule